// File: doc/BRIEF.md
# Serial Boot Image Loader

This block takes over start-up when the chip is strapped into its serial boot mode. It watches a byte-wide receive stream from a UART and discards everything until one agreed handshake byte arrives. After that handshake it treats the next fixed number of bytes as a raw binary image. Each byte goes into on-chip RAM through a write port, at consecutive addresses that start at a fixed load address. Once the final byte has been written, the block raises a single-cycle jump request that carries the load address, so execution starts at the first image byte.

The sequencer has five named states. `LDR_OFF` is the reset state. It moves to `LDR_WAIT` on the first clock with the boot-mode strap high. `LDR_WAIT` moves to `LDR_LOAD` when the handshake byte arrives and stays where it is for any other byte. `LDR_LOAD` writes one byte per valid receive cycle and moves to `LDR_JUMP` on the last image byte. `LDR_JUMP` always moves to `LDR_HALT`. `LDR_HALT` is terminal until reset. All RAM and jump outputs are registered.

Top module: `boot_loader_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `ram_we_o`, `ram_addr_o`, `ram_wdata_o`, `jump_req_o` and `jump_addr_o` are all zero. After each reset the image address starts again at `BASE_ADDR`.
- R2: While `boot_mode_i` is low in `LDR_OFF`, received bytes, including the handshake value `INIT_CHAR`, cause no RAM write and no jump.
- R3: In `LDR_WAIT`, a received byte other than `INIT_CHAR` is ignored and the sequencer stays waiting. The handshake byte itself is never written to RAM.
- R4: In `LDR_LOAD`, a byte received with `rx_valid_i` high at clock edge k produces, in the cycle after edge k, `ram_we_o`=1, `ram_addr_o`=`BASE_ADDR`+n (where n counts image bytes from 0) and `ram_wdata_o` equal to that byte. `ram_we_o` lasts one cycle.
- R5: Exactly `IMG_BYTES` bytes are written. Any byte received after the last image byte causes no write.
- R6: In the cycle after the write of the last image byte, `jump_req_o`=1 and `jump_addr_o`=`BASE_ADDR`. `jump_addr_o` is zero whenever `jump_req_o` is low.
- R7: The jump request lasts exactly one cycle. After it, no further write or jump occurs until reset, even if `INIT_CHAR` is received again.
- R8: Cycles with `rx_valid_i` low during loading produce no write and do not advance the image address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_mode_i | input | 1 | Serial boot strap, sampled in `LDR_OFF` |
| rx_valid_i | input | 1 | Receive byte valid, one cycle per byte |
| rx_data_i | input | DATA_W | Received byte |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | ADDR_W | RAM write address |
| ram_wdata_o | output | DATA_W | RAM write data |
| jump_req_o | output | 1 | Single-cycle request to start execution |
| jump_addr_o | output | ADDR_W | Start address carried with the jump request |

## Verification
The bench builds the block with `IMG_BYTES`=8, `BASE_ADDR`=16'hFA40 and `INIT_CHAR`=8'h3C. The short image brings the last-byte boundary, the jump pulse and the post-jump halt within a few dozen cycles. A non-zero handshake value keeps idle zero data on the receive bus distinct from a real handshake. Stray bytes before the handshake, idle gaps inside the image, and a second boot after a new reset are all driven against this image.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;
    typedef enum logic [2:0] {
        LDR_OFF   = 3'd0,
        LDR_WAIT  = 3'd1,
        LDR_LOAD  = 3'd2,
        LDR_JUMP  = 3'd3,
        LDR_HALT  = 3'd4
    } ldr_state_e;
endpackage

// File: rtl/boot_ldr_init_det.sv
module boot_ldr_init_det #(
    parameter int unsigned          DATA_W    = 8,
    parameter logic [DATA_W-1:0]    INIT_CHAR = '0
) (
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              hit_o
);
    always_comb begin
        hit_o = valid_i && (data_i == INIT_CHAR);
    end
endmodule

// File: rtl/boot_ldr_cnt.sv
module boot_ldr_cnt #(
    parameter int unsigned LIMIT = 32,
    localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             last_o
);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(LIMIT - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (inc_i) begin
            count_o <= (count_o == LAST_VAL) ? '0 : count_o + 1'b1;
        end
    end

    always_comb begin
        last_o = (count_o == LAST_VAL);
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= LAST_VAL);  // R5
endmodule

// File: rtl/boot_loader_seq.sv
module boot_loader_seq
    import boot_ldr_pkg::*;
#(
    parameter int unsigned          DATA_W    = 8,
    parameter int unsigned          ADDR_W    = 16,
    parameter int unsigned          IMG_BYTES = 32,
    parameter logic [ADDR_W-1:0]    BASE_ADDR = 16'hFA40,
    parameter logic [DATA_W-1:0]    INIT_CHAR = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_mode_i,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic              ram_we_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [DATA_W-1:0] ram_wdata_o,
    output logic              jump_req_o,
    output logic [ADDR_W-1:0] jump_addr_o
);
    localparam int unsigned CNT_W = (IMG_BYTES > 1) ? $clog2(IMG_BYTES) : 1;

    ldr_state_e       state_q, state_d;
    logic             init_hit;
    logic             take_byte;
    logic [CNT_W-1:0] byte_idx;
    logic             byte_last;

    boot_ldr_init_det #(
        .DATA_W    (DATA_W),
        .INIT_CHAR (INIT_CHAR)
    ) u_init_det (
        .valid_i (rx_valid_i),
        .data_i  (rx_data_i),
        .hit_o   (init_hit)
    );

    assign take_byte = (state_q == LDR_LOAD) && rx_valid_i;

    boot_ldr_cnt #(
        .LIMIT (IMG_BYTES)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (take_byte),
        .count_o (byte_idx),
        .last_o  (byte_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LDR_OFF:  if (boot_mode_i)            state_d = LDR_WAIT;
            LDR_WAIT: if (init_hit)               state_d = LDR_LOAD;
            LDR_LOAD: if (take_byte && byte_last) state_d = LDR_JUMP;
            LDR_JUMP:                             state_d = LDR_HALT;
            LDR_HALT:                             state_d = LDR_HALT;
            default:                              state_d = LDR_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LDR_OFF;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we_o    <= 1'b0;
            ram_addr_o  <= '0;
            ram_wdata_o <= '0;
            jump_req_o  <= 1'b0;
            jump_addr_o <= '0;
        end else begin
            ram_we_o <= take_byte;
            if (take_byte) begin
                ram_addr_o  <= BASE_ADDR + ADDR_W'(byte_idx);
                ram_wdata_o <= rx_data_i;
            end
            jump_req_o  <= (state_q == LDR_JUMP);
            jump_addr_o <= (state_q == LDR_JUMP) ? BASE_ADDR : '0;
        end
    end

    AST_WE_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> $past(state_q) == LDR_LOAD);  // R4
    AST_ADDR_IN_IMAGE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> (ram_addr_o - BASE_ADDR) < ADDR_W'(IMG_BYTES));  // R5
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LDR_WAIT && !init_hit) |=> state_q == LDR_WAIT);  // R3
    AST_JUMP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        jump_req_o |-> jump_addr_o == BASE_ADDR);  // R6
    AST_JUMP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        jump_req_o |=> !jump_req_o);  // R7
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LDR_HALT) |=> !ram_we_o);  // R7
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LDR_OFF) |=> !ram_we_o && !jump_req_o);  // R2
endmodule

// File: tb/boot_loader_seq_tb_top.sv
module boot_loader_seq_tb_top;
    localparam int unsigned       IMG   = 8;
    localparam logic [15:0]       BASE  = 16'hFA40;
    localparam logic [7:0]        INITC = 8'h3C;

    // {idle gap before byte, byte value}
    localparam logic [8:0] VEC [IMG] = '{
        {1'b0, 8'hA1}, {1'b1, 8'h00}, {1'b0, 8'hFF}, {1'b0, 8'h3C},
        {1'b1, 8'h5A}, {1'b0, 8'h7E}, {1'b1, 8'h81}, {1'b0, 8'hC3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_mode_i = 1'b0;
    logic        rx_valid_i = 1'b0;
    logic [7:0]  rx_data_i = '0;
    logic        ram_we_o;
    logic [15:0] ram_addr_o;
    logic [7:0]  ram_wdata_o;
    logic        jump_req_o;
    logic [15:0] jump_addr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    boot_loader_seq #(
        .IMG_BYTES (IMG),
        .BASE_ADDR (BASE),
        .INIT_CHAR (INITC)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .boot_mode_i (boot_mode_i),
        .rx_valid_i  (rx_valid_i),
        .rx_data_i   (rx_data_i),
        .ram_we_o    (ram_we_o),
        .ram_addr_o  (ram_addr_o),
        .ram_wdata_o (ram_wdata_o),
        .jump_req_o  (jump_req_o),
        .jump_addr_o (jump_addr_o)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one byte; returns at the negedge after the capturing edge
    task automatic send(input logic [7:0] d);
        @(negedge clk);
        rx_valid_i = 1'b1;
        rx_data_i  = d;
        @(negedge clk);
        rx_valid_i = 1'b0;
        rx_data_i  = '0;
    endtask

    task automatic quiet(input string req);
        chk(!ram_we_o, req, ram_we_o, 0);
        chk(!jump_req_o && jump_addr_o == 0, req, jump_addr_o, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        boot_mode_i = 1'b0;
        repeat (2) @(negedge clk);
        chk(!ram_we_o && ram_addr_o == 0 && ram_wdata_o == 0, "R1 ram", ram_addr_o, 0);
        chk(!jump_req_o && jump_addr_o == 0, "R1 jump", jump_addr_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ram_we_o && !jump_req_o, "R1 post", ram_we_o, 0);
    endtask

    initial begin
        do_reset();

        // R2: boot mode low, even handshake is ignored
        send(INITC);
        quiet("R2 init");
        send(8'h11);
        quiet("R2 data");

        // enter WAIT
        @(negedge clk);
        boot_mode_i = 1'b1;
        @(negedge clk);
        send(8'h11);
        quiet("R3 stray");
        send(8'hC3);
        quiet("R3 stray2");
        send(INITC);
        quiet("R3 init not stored");

        // image load
        for (int i = 0; i < IMG; i++) begin
            if (VEC[i][8]) begin
                @(negedge clk);
                chk(!ram_we_o, "R8 gap", ram_we_o, 0);
            end
            send(VEC[i][7:0]);
            chk(ram_we_o, "R4 we", ram_we_o, 1);
            chk(ram_addr_o == BASE + 16'(i), "R4 addr", ram_addr_o, BASE + 16'(i));
            chk(ram_wdata_o == VEC[i][7:0], "R4 data", ram_wdata_o, VEC[i][7:0]);
            chk(!jump_req_o, "R6 early", jump_req_o, 0);
        end
        @(negedge clk);
        chk(!ram_we_o, "R4 single", ram_we_o, 0);
        chk(jump_req_o, "R6 req", jump_req_o, 1);
        chk(jump_addr_o == BASE, "R6 addr", jump_addr_o, BASE);
        @(negedge clk);
        chk(!jump_req_o && jump_addr_o == 0, "R7 pulse", jump_addr_o, 0);

        // R5/R7: bytes after the image
        send(8'h99);
        quiet("R5 extra");
        send(INITC);
        quiet("R7 reinit");
        send(8'h42);
        quiet("R7 halted");

        // R1: second boot restarts at base
        do_reset();
        boot_mode_i = 1'b1;
        @(negedge clk);
        send(INITC);
        for (int i = 0; i < 3; i++) begin
            send(8'(8'h10 + i));
            chk(ram_we_o && ram_addr_o == BASE + 16'(i), "R1 restart addr",
                ram_addr_o, BASE + 16'(i));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule